// File: doc/BRIEF.md
# Vertical Format Unit with Loader

This block holds the vertical form of a line printer: a table of up to 143 twelve-bit entries, one per printed line, where each bit marks a channel stop on that line. Bit 0 is top of form. A host first loads the form as a byte stream. Each entry arrives as two six-bit halves, and the frame is marked by start and stop codes. The host can then issue two kinds of command. An advance moves the paper a fixed number of lines. A channel search walks forward to the next line that carries a given channel stop.

The block keeps the current line pointer, the valid length of the form and a 12-bit page counter. The counter counts down each time the paper comes to rest on a top-of-form line. When it reaches zero the block raises a page-zero flag and tells the caller to stop. Commands step one entry per clock, and `busy` stays high during the walk. Each command ends with a one-cycle response. The response gives the lines to feed, whether a form feed is due, whether the search failed, and whether printing must stop. The mechanical paper drive sits outside this block.

Top module: `vfu_engine`

## Requirements
- R1: A load byte in the range 0xEC to 0xEE opens a frame. It sets the form length to zero and expects the low half of an entry next. The line pointer is not changed.
- R2: Inside a frame, data bytes are taken in pairs. Bits 5:0 of the first byte become entry bits 5:0, and bits 5:0 of the second become entry bits 11:6. Bits 7:6 of each byte are dropped. Each complete pair adds one to the length. Pairs beyond DEPTH entries are discarded, so the length stops at DEPTH.
- R3: Byte 0xEF closes the frame and sets the line pointer to zero. If an odd number of data bytes was received, the length is forced to zero. Data bytes received outside a frame are ignored.
- R4: `vfu_valid` is high exactly when the form length is nonzero.
- R5: An advance of n lines (n in 0..15) steps the pointer n times, wrapping at the length, one step per cycle. The response comes n cycles after the command edge, with `rsp_lines` = n. When n = 0, the response comes on the command edge itself and nothing changes. With length zero, an advance answers at once with stop = 1 and no change.
- R6: When an advance or a nonzero-channel search ends on an entry whose bit 0 is set, the page counter decrements by one. If the new value is zero, `page_zero` is set and stop = 1. Otherwise `page_zero` is cleared.
- R7: A search takes a channel code from `cmd_arg`. Codes 12 to 15 mean channel 7. The pointer steps forward with wraparound, one entry per cycle, for at most length steps. If the channel bit is found on step k, the response comes k cycles after the command edge, with `rsp_lines` = k and the pointer left on that entry.
- R8: When a search for channel 0 finds its entry, the response has `rsp_ff` = 1. `rsp_lines` is 1 if `col_nz` was high with the command, and 0 otherwise. The page counter then follows R6.
- R9: If a search finds no match within length steps, the length is cleared on the final step and the response carries `rsp_miss` = 1 and stop = 1. A search with length zero answers at once in the same way.
- R10: `busy` is high from the command edge until the response. While busy, commands and load bytes are ignored, and `busy` and `rsp_valid` are never high together.
- R11: `page_wr` loads the page counter from `page_val` and leaves `page_zero` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Load byte strobe |
| ld_byte | input | 8 | Load byte: frame code or data half |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 0 = advance, 1 = channel search |
| cmd_arg | input | ARG_W | Line count for an advance, channel code for a search |
| col_nz | input | 1 | Print column is nonzero (a newline is pending before a form feed) |
| page_wr | input | 1 | Page counter write strobe |
| page_val | input | PAGE_W | Page counter write value |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_stop | output | 1 | Printing must stop |
| rsp_miss | output | 1 | Search found no match (or the form was empty) |
| rsp_ff | output | 1 | Form feed is due |
| rsp_lines | output | LEN_W | Lines to feed |
| line_ptr | output | LEN_W | Current line pointer |
| form_len | output | LEN_W | Valid form length |
| vfu_valid | output | 1 | Form is usable |
| page_count | output | PAGE_W | Page counter |
| page_zero | output | 1 | Page counter has reached zero |

## Verification
A load byte is visible in `form_len` and `line_ptr` one edge after it is accepted. A command answers on the command edge itself when nothing needs to move: an advance of zero or an empty form. Otherwise it answers exactly n edges later for an advance of n lines, or k edges later for a search that stops on step k. The page counter and flag change on the same edge as the response. The scoreboard stores, for each command, the cycle number when its response is due. The monitor, sampling on falling edges, compares that cycle with the cycle where `rsp_valid` is seen, and checks pointer and response fields at that same point. Status checks after a load or a page write are made only after the following falling edge.

// File: rtl/vfu_pkg.sv
// vfu_pkg: shared constants and state types for the vertical format unit.
// Assumes entries are 12 bits wide, with one bit per channel and channel 0 as top of form.
package vfu_pkg;
    localparam int ENTRY_W     = 12;
    localparam int HALF_W      = 6;
    localparam int TOF_CH      = 0;
    localparam int FALLBACK_CH = 7;

    localparam logic [7:0] FRAME_OPEN_LO = 8'hEC;
    localparam logic [7:0] FRAME_OPEN_HI = 8'hEE;
    localparam logic [7:0] FRAME_CLOSE   = 8'hEF;

    typedef enum logic { OP_ADVANCE = 1'b0, OP_SEARCH = 1'b1 } vfu_op_e;

    typedef enum logic [1:0] { ST_IDLE, ST_ADV, ST_SRCH } step_state_e;
endpackage

// File: rtl/vfu_loader.sv
// vfu_loader: turns the framed byte stream into entry writes and keeps the form length.
// Assumes the caller gates byte_vld while a command is running, so len_clr never
// coincides with a byte.
module vfu_loader import vfu_pkg::*; #(
    parameter int DEPTH = 143,
    parameter int LEN_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_vld,
    input  logic [7:0]         byte_in,
    input  logic               len_clr,
    output logic               wr_en,
    output logic [LEN_W-1:0]   wr_addr,
    output logic [ENTRY_W-1:0] wr_data,
    output logic [LEN_W-1:0]   form_len,
    output logic               ptr_clr
);
    logic              armed;
    logic              odd_phase;
    logic [HALF_W-1:0] low_half;
    logic [LEN_W-1:0]  len_q;
    logic              is_open;
    logic              is_close;
    logic              room;

    // Classify the incoming byte and form the write request.
    always_comb begin
        is_open  = (byte_in >= FRAME_OPEN_LO) && (byte_in <= FRAME_OPEN_HI);
        is_close = (byte_in == FRAME_CLOSE);
        room     = (len_q < LEN_W'(DEPTH));
        wr_en    = byte_vld && !is_open && !is_close && armed && odd_phase && room;
        wr_addr  = len_q;
        wr_data  = {byte_in[HALF_W-1:0], low_half};
        ptr_clr  = byte_vld && is_close;
        form_len = len_q;
    end

    // Frame state, half-entry phase and length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            odd_phase <= 1'b0;
            low_half  <= '0;
            len_q     <= '0;
        end else if (len_clr) begin
            len_q <= '0;
        end else if (byte_vld) begin
            if (is_open) begin
                armed     <= 1'b1;
                odd_phase <= 1'b0;
                len_q     <= '0;
            end else if (is_close) begin
                if (armed && odd_phase) len_q <= '0;
                armed     <= 1'b0;
                odd_phase <= 1'b0;
            end else if (armed) begin
                if (!odd_phase) begin
                    low_half  <= byte_in[HALF_W-1:0];
                    odd_phase <= 1'b1;
                end else begin
                    odd_phase <= 1'b0;
                    if (room) len_q <= len_q + LEN_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/vfu_store.sv
// vfu_store: flop-based form table with one write port and one combinational read port.
// Assumes addresses at or above DEPTH read back as zero.
module vfu_store import vfu_pkg::*; #(
    parameter int DEPTH = 143,
    parameter int LEN_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [LEN_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [LEN_W-1:0]   rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);
    logic [ENTRY_W-1:0] mem [DEPTH];

    // Clear on reset, write on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read the addressed entry without delay.
    always_comb begin
        rd_data = (rd_addr < LEN_W'(DEPTH)) ? mem[rd_addr] : '0;
    end
endmodule

// File: rtl/vfu_stepper.sv
// vfu_stepper: runs advance and channel-search commands one entry per clock, and
// owns the line pointer and the page counter.
// Assumes form_len is stable while busy and that entry is the table word at rd_addr.
module vfu_stepper import vfu_pkg::*; #(
    parameter int LEN_W  = 8,
    parameter int PAGE_W = 12,
    parameter int ARG_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_op,
    input  logic [ARG_W-1:0]   cmd_arg,
    input  logic               col_nz,
    input  logic [LEN_W-1:0]   form_len,
    input  logic [ENTRY_W-1:0] entry,
    input  logic               page_wr,
    input  logic [PAGE_W-1:0]  page_val,
    input  logic               ptr_clr,
    output logic [LEN_W-1:0]   rd_addr,
    output logic [LEN_W-1:0]   line_ptr,
    output logic [PAGE_W-1:0]  page_count,
    output logic               page_zero,
    output logic               busy,
    output logic               rsp_valid,
    output logic               rsp_stop,
    output logic               rsp_miss,
    output logic               rsp_ff,
    output logic [LEN_W-1:0]   rsp_lines,
    output logic               len_clr
);
    step_state_e       state, state_n;
    logic [LEN_W-1:0]  ptr, ptr_n, ptr_inc, nxt;
    logic [LEN_W-1:0]  steps, steps_n, steps_inc, goal;
    logic [ARG_W-1:0]  chan;
    logic              col_q;
    logic [PAGE_W-1:0] page, page_dec;
    logic              pz;
    logic              fin, f_tof, f_ff, f_miss, f_inval, f_stop;
    logic [LEN_W-1:0]  f_lines;

    // Next pointer, step count and finish decision for this cycle.
    always_comb begin
        ptr_inc   = ptr + LEN_W'(1);
        nxt       = (ptr_inc >= form_len) ? '0 : ptr_inc;
        steps_inc = steps + LEN_W'(1);
        page_dec  = page - PAGE_W'(1);
        state_n   = state;
        ptr_n     = ptr;
        steps_n   = steps;
        fin       = 1'b0;
        f_tof     = 1'b0;
        f_ff      = 1'b0;
        f_miss    = 1'b0;
        f_inval   = 1'b0;
        f_lines   = '0;
        case (state)
            ST_IDLE: if (cmd_valid) begin
                if (form_len == '0) begin
                    fin     = 1'b1;
                    f_inval = 1'b1;
                    f_miss  = (vfu_op_e'(cmd_op) == OP_SEARCH);
                end else if (vfu_op_e'(cmd_op) == OP_ADVANCE && cmd_arg == '0) begin
                    fin = 1'b1;
                end else begin
                    state_n = (vfu_op_e'(cmd_op) == OP_ADVANCE) ? ST_ADV : ST_SRCH;
                    steps_n = '0;
                end
            end
            ST_ADV: begin
                ptr_n   = nxt;
                steps_n = steps_inc;
                if (steps_inc == goal) begin
                    fin     = 1'b1;
                    f_tof   = entry[TOF_CH];
                    f_lines = goal;
                    state_n = ST_IDLE;
                end
            end
            ST_SRCH: begin
                ptr_n   = nxt;
                steps_n = steps_inc;
                if (entry[chan]) begin
                    fin     = 1'b1;
                    f_tof   = entry[TOF_CH];
                    state_n = ST_IDLE;
                    if (chan == ARG_W'(TOF_CH)) begin
                        f_ff    = 1'b1;
                        f_lines = LEN_W'(col_q);
                    end else begin
                        f_lines = steps_inc;
                    end
                end else if (steps_inc == form_len) begin
                    fin     = 1'b1;
                    f_miss  = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        f_stop  = f_inval || f_miss || (f_tof && page_dec == '0);
        len_clr = f_miss;
        rd_addr = nxt;
    end

    // Command state, pointer, latched arguments and page counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ptr       <= '0;
            steps     <= '0;
            goal      <= '0;
            chan      <= '0;
            col_q     <= 1'b0;
            page      <= '0;
            pz        <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_stop  <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_ff    <= 1'b0;
            rsp_lines <= '0;
        end else begin
            state <= state_n;
            steps <= steps_n;
            ptr   <= ptr_clr ? '0 : ptr_n;
            if (state == ST_IDLE && cmd_valid) begin
                goal  <= LEN_W'(cmd_arg);
                chan  <= (cmd_arg > ARG_W'(ENTRY_W - 1)) ? ARG_W'(FALLBACK_CH) : cmd_arg;
                col_q <= col_nz;
            end
            if (page_wr) begin
                page <= page_val;
            end else if (fin && f_tof) begin
                page <= page_dec;
                pz   <= (page_dec == '0);
            end
            rsp_valid <= fin;
            if (fin) begin
                rsp_stop  <= f_stop;
                rsp_miss  <= f_miss;
                rsp_ff    <= f_ff;
                rsp_lines <= f_lines;
            end
        end
    end

    // Expose the state to the outputs.
    always_comb begin
        line_ptr   = ptr;
        page_count = page;
        page_zero  = pz;
        busy       = (state != ST_IDLE);
    end
endmodule

// File: rtl/vfu_engine.sv
// vfu_engine: top of the vertical format unit. It joins the loader, the table and
// the command stepper.
// Assumes one command at a time. Load bytes and commands that arrive while busy are dropped.
module vfu_engine import vfu_pkg::*; #(
    parameter  int DEPTH  = 143,
    parameter  int PAGE_W = 12,
    parameter  int ARG_W  = 4,
    localparam int LEN_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [7:0]        ld_byte,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic              col_nz,
    input  logic              page_wr,
    input  logic [PAGE_W-1:0] page_val,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_stop,
    output logic              rsp_miss,
    output logic              rsp_ff,
    output logic [LEN_W-1:0]  rsp_lines,
    output logic [LEN_W-1:0]  line_ptr,
    output logic [LEN_W-1:0]  form_len,
    output logic              vfu_valid,
    output logic [PAGE_W-1:0] page_count,
    output logic              page_zero
);
    logic               ld_ok;
    logic               wr_en;
    logic [LEN_W-1:0]   wr_addr;
    logic [ENTRY_W-1:0] wr_data;
    logic [LEN_W-1:0]   rd_addr;
    logic [ENTRY_W-1:0] rd_data;
    logic               len_clr;
    logic               ptr_clr;

    // Drop load bytes while a command walks the table.
    always_comb begin
        ld_ok     = ld_valid && !busy;
        vfu_valid = (form_len != '0);
    end

    vfu_loader #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_loader (
        .clk(clk), .rst_n(rst_n), .byte_vld(ld_ok), .byte_in(ld_byte),
        .len_clr(len_clr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .form_len(form_len), .ptr_clr(ptr_clr)
    );

    vfu_store #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    vfu_stepper #(.LEN_W(LEN_W), .PAGE_W(PAGE_W), .ARG_W(ARG_W)) u_stepper (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .col_nz(col_nz), .form_len(form_len), .entry(rd_data),
        .page_wr(page_wr), .page_val(page_val), .ptr_clr(ptr_clr),
        .rd_addr(rd_addr), .line_ptr(line_ptr), .page_count(page_count),
        .page_zero(page_zero), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_stop(rsp_stop), .rsp_miss(rsp_miss), .rsp_ff(rsp_ff),
        .rsp_lines(rsp_lines), .len_clr(len_clr)
    );
endmodule

// File: rtl/vfu_chk.sv
// vfu_chk: temporal properties of vfu_engine, attached through bind.
// Assumes it sees the top-level ports only.
module vfu_chk #(
    parameter int DEPTH = 143,
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_valid,
    input logic [7:0]       ld_byte,
    input logic             busy,
    input logic             rsp_valid,
    input logic             rsp_stop,
    input logic             rsp_miss,
    input logic             rsp_ff,
    input logic [LEN_W-1:0] rsp_lines,
    input logic [LEN_W-1:0] line_ptr,
    input logic [LEN_W-1:0] form_len,
    input logic             page_zero
);
    // R10
    busy_rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && rsp_valid));

    // R6
    pz_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(page_zero) |-> (rsp_valid && rsp_stop));

    // R9
    miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (form_len == '0 && rsp_stop));

    // R2
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        form_len <= LEN_W'(DEPTH));

    // R3
    close_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !busy && ld_byte == 8'hEF) |=> (line_ptr == '0));

    // R1
    open_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !busy && ld_byte >= 8'hEC && ld_byte <= 8'hEE) |=> (form_len == '0));

    // R8
    ff_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ff) |-> (rsp_lines <= LEN_W'(1) && !rsp_miss));

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && form_len != '0) |-> (line_ptr < form_len));
endmodule

bind vfu_engine vfu_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_vfu_chk (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_byte(ld_byte),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_stop(rsp_stop),
    .rsp_miss(rsp_miss), .rsp_ff(rsp_ff), .rsp_lines(rsp_lines),
    .line_ptr(line_ptr), .form_len(form_len), .page_zero(page_zero)
);

// File: tb/test_vfu_engine.sv
// test_vfu_engine: scoreboard bench. The driver queues the expected responses and a
// falling-edge monitor checks them, including the cycle in which each one arrives.
module test_vfu_engine;
    localparam int DEPTH  = 143;
    localparam int PAGE_W = 12;
    localparam int ARG_W  = 4;
    localparam int LEN_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_valid = 1'b0;
    logic [7:0]        ld_byte = '0;
    logic              cmd_valid = 1'b0;
    logic              cmd_op = 1'b0;
    logic [ARG_W-1:0]  cmd_arg = '0;
    logic              col_nz = 1'b0;
    logic              page_wr = 1'b0;
    logic [PAGE_W-1:0] page_val = '0;
    logic              busy, rsp_valid, rsp_stop, rsp_miss, rsp_ff;
    logic [LEN_W-1:0]  rsp_lines, line_ptr, form_len;
    logic              vfu_valid, page_zero;
    logic [PAGE_W-1:0] page_count;

    vfu_engine #(.DEPTH(DEPTH), .PAGE_W(PAGE_W), .ARG_W(ARG_W)) i_vfu_engine (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_byte(ld_byte),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg), .col_nz(col_nz),
        .page_wr(page_wr), .page_val(page_val), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_stop(rsp_stop), .rsp_miss(rsp_miss), .rsp_ff(rsp_ff),
        .rsp_lines(rsp_lines), .line_ptr(line_ptr), .form_len(form_len),
        .vfu_valid(vfu_valid), .page_count(page_count), .page_zero(page_zero)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    lines;
        bit    stop;
        bit    ff;
        bit    miss;
        int    ptr;
        int    due;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   rsp_cnt = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    // Monitor: pop and compare each response at the falling edge.
    always @(negedge clk) begin : monitor
        exp_t e;
        if (rst_n && rsp_valid) begin
            rsp_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected response: actual 1 expected 0");
            end else begin
                e = exp_q.pop_front();
                check(rsp_lines == LEN_W'(e.lines) && rsp_stop == e.stop && rsp_ff == e.ff &&
                      rsp_miss == e.miss && line_ptr == LEN_W'(e.ptr),
                      $sformatf("%s lines/stop/ff/miss/ptr actual %0d/%0b/%0b/%0b/%0d expected %0d/%0b/%0b/%0b/%0d",
                                e.tag, rsp_lines, rsp_stop, rsp_ff, rsp_miss, line_ptr,
                                e.lines, e.stop, e.ff, e.miss, e.ptr));
                check(cyc == e.due, $sformatf("%s response cycle actual %0d expected %0d",
                                              e.tag, cyc, e.due));
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_byte  = b;
        @(posedge clk);
        #1 ld_valid = 1'b0;
    endtask

    task automatic set_page(input int v);
        @(negedge clk);
        page_wr  = 1'b1;
        page_val = PAGE_W'(v);
        @(posedge clk);
        #1 page_wr = 1'b0;
    endtask

    task automatic issue(input bit op, input int arg, input bit col, input int lines,
                         input bit stop, input bit ff, input bit miss, input int ptr,
                         input int lat, input string tag);
        exp_t e;
        @(negedge clk);
        e.lines = lines; e.stop = stop; e.ff = ff; e.miss = miss;
        e.ptr = ptr; e.due = cyc + 1 + lat; e.tag = tag;
        exp_q.push_back(e);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_arg   = ARG_W'(arg);
        col_nz    = col;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input bit op, input int arg, input bit col, input int lines,
                       input bit stop, input bit ff, input bit miss, input int ptr,
                       input int lat, input string tag);
        issue(op, arg, col, lines, stop, ff, miss, ptr, lat, tag);
        drain();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin : driver
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R4, R10)
        check(!vfu_valid && form_len == 0 && line_ptr == 0 && !busy && !page_zero && !rsp_valid,
              $sformatf("R4 reset valid/len/ptr/busy/pz actual %0b/%0d/%0d/%0b/%0b expected 0/0/0/0/0",
                        vfu_valid, form_len, line_ptr, busy, page_zero));

        // R3: data bytes outside a frame are ignored
        send_byte(8'h01); send_byte(8'h00);
        @(negedge clk);
        check(form_len == 0, $sformatf("R3 stray data len actual %0d expected 0", form_len));

        // R1/R2: six-entry form; entry1 has junk in bits 7:6 only
        send_byte(8'hEC);
        send_byte(8'h01); send_byte(8'h00);
        send_byte(8'hC0); send_byte(8'h40);
        send_byte(8'h08); send_byte(8'h00);
        send_byte(8'h00); send_byte(8'h00);
        send_byte(8'h00); send_byte(8'h02);
        send_byte(8'h00); send_byte(8'h20);
        send_byte(8'hEF);
        @(negedge clk);
        check(form_len == 6 && vfu_valid && line_ptr == 0,
              $sformatf("R2 R4 load len/valid/ptr actual %0d/%0b/%0d expected 6/1/0",
                        form_len, vfu_valid, line_ptr));

        set_page(3);
        @(negedge clk);
        check(page_count == 3 && !page_zero,
              $sformatf("R11 page write actual %0d/%0b expected 3/0", page_count, page_zero));

        run(1'b0, 2, 1'b0, 2, 1'b0, 1'b0, 1'b0, 2, 2, "R5 advance 2");

        // R7 wrap search; R10 command and load byte during busy are dropped
        issue(1'b1, 3, 1'b0, 6, 1'b0, 1'b0, 1'b0, 2, 6, "R7 search wraps to own line");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 1'b0; cmd_arg = 4'd1;
        ld_valid = 1'b1; ld_byte = 8'hEC;
        @(posedge clk);
        #1 cmd_valid = 1'b0; ld_valid = 1'b0;
        drain();
        repeat (3) @(negedge clk);
        check(rsp_cnt == 2 && form_len == 6,
              $sformatf("R10 busy drop rsp/len actual %0d/%0d expected 2/6", rsp_cnt, form_len));

        run(1'b1, 13, 1'b0, 2, 1'b0, 1'b0, 1'b0, 4, 2, "R7 code 13 means channel 7");
        run(1'b1, 0, 1'b1, 1, 1'b0, 1'b1, 1'b0, 0, 2, "R8 top of form with newline");
        check(page_count == 2, $sformatf("R8 page after FF actual %0d expected 2", page_count));

        run(1'b0, 6, 1'b0, 6, 1'b0, 1'b0, 1'b0, 0, 6, "R6 advance onto TOF");
        check(page_count == 1 && !page_zero,
              $sformatf("R6 page actual %0d/%0b expected 1/0", page_count, page_zero));

        run(1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 0, "R5 advance 0");
        check(page_count == 1, $sformatf("R5 page after advance 0 actual %0d expected 1", page_count));

        run(1'b0, 3, 1'b0, 3, 1'b0, 1'b0, 1'b0, 3, 3, "R5 advance 3");
        run(1'b1, 0, 1'b0, 0, 1'b1, 1'b1, 1'b0, 0, 3, "R6 R8 FF to page zero");
        check(page_count == 0 && page_zero,
              $sformatf("R6 zero actual %0d/%0b expected 0/1", page_count, page_zero));

        set_page(5);
        @(negedge clk);
        check(page_count == 5 && page_zero,
              $sformatf("R11 write keeps flag actual %0d/%0b expected 5/1", page_count, page_zero));
        run(1'b0, 6, 1'b0, 6, 1'b0, 1'b0, 1'b0, 0, 6, "R6 flag clears");
        check(page_count == 4 && !page_zero,
              $sformatf("R6 clear actual %0d/%0b expected 4/0", page_count, page_zero));

        run(1'b1, 5, 1'b0, 0, 1'b1, 1'b0, 1'b1, 0, 6, "R9 search miss");
        check(form_len == 0 && !vfu_valid,
              $sformatf("R9 R4 after miss len/valid actual %0d/%0b expected 0/0", form_len, vfu_valid));

        run(1'b0, 2, 1'b0, 0, 1'b1, 1'b0, 1'b0, 0, 0, "R5 advance on empty form");
        run(1'b1, 2, 1'b0, 0, 1'b1, 1'b0, 1'b1, 0, 0, "R9 search on empty form");

        // R3: odd data count invalidates
        send_byte(8'hED);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
        send_byte(8'hEF);
        @(negedge clk);
        check(form_len == 0, $sformatf("R3 odd count len actual %0d expected 0", form_len));

        // R2: overlong load is capped
        send_byte(8'hEE);
        for (int i = 0; i < 150; i++) begin
            send_byte(8'h01); send_byte(8'h00);
        end
        send_byte(8'hEF);
        @(negedge clk);
        check(form_len == 143, $sformatf("R2 cap len actual %0d expected 143", form_len));
        run(1'b0, 15, 1'b0, 15, 1'b0, 1'b0, 1'b0, 15, 15, "R5 R6 advance 15 on long form");
        check(page_count == 3, $sformatf("R6 page actual %0d expected 3", page_count));

        // R1: an open code mid-state resets length, pointer untouched
        send_byte(8'hEC);
        @(negedge clk);
        check(form_len == 0 && line_ptr == 15,
              $sformatf("R1 open len/ptr actual %0d/%0d expected 0/15", form_len, line_ptr));

        // R2: bit placement, entry = bits 0, 5, 10
        send_byte(8'h21); send_byte(8'h10); send_byte(8'hEF);
        @(negedge clk);
        check(form_len == 1 && line_ptr == 0,
              $sformatf("R2 R3 single entry len/ptr actual %0d/%0d expected 1/0", form_len, line_ptr));
        run(1'b1, 10, 1'b0, 1, 1'b0, 1'b0, 1'b0, 0, 1, "R2 high half bit 10");
        run(1'b1, 5, 1'b0, 1, 1'b0, 1'b0, 1'b0, 0, 1, "R2 low half bit 5");
        check(page_count == 1, $sformatf("R6 page actual %0d expected 1", page_count));
        run(1'b1, 4, 1'b0, 0, 1'b1, 1'b0, 1'b1, 0, 1, "R9 absent bit 4");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule